// File: doc/BRIEF.md
# Frame-Difference Foreground Segmenter

This block separates moving objects from a fixed scene in a streaming video path. Every pixel clock it may receive one live RGB pixel and the co-located pixel of a stored background frame. For each colour component it forms the absolute difference of the two values. It compares each difference against a per-component threshold and emits one bit per pixel: 1 for foreground, 0 for background. The valid strobe, frame sync and row sync travel through the same two register stages as the data, so downstream logic sees them aligned with the flag.

The thresholds are not fixed constants. While a frame streams through, the block sums each component's differences and counts the valid pixels. At the next frame sync it divides each sum by the count, giving the mean difference per component. Those means become the thresholds for the following frame. Until the first non-empty frame has been measured, the input `dflt_thr` serves as the threshold for all three components.

The division is done by a small restoring-divider state machine that is shared by the components. It has four states:

- `DV_IDLE`: waits for a frame sync. It moves to `DV_LOAD` only if the frame that just ended held at least one pixel. In that case it latches the three sums and the count.
- `DV_LOAD`: loads the dividend of the current component and moves to `DV_SHIFT`.
- `DV_SHIFT`: runs one quotient bit per cycle. After `ACC_W` bits it moves to `DV_STORE`.
- `DV_STORE`: writes the quotient into that component's threshold. It returns to `DV_LOAD` for the next component, or to `DV_IDLE` after the last one.

A full update takes `3*(ACC_W+2)+2` cycles after `fsync_i`. The first valid pixel of a frame must come no earlier than that. A frame sync that arrives while a division is still running is not measured.

Top module: `frame_seg_top`

## Requirements
- R1: Each component's difference is the absolute value of live minus background. It is the same whichever of the two values is larger. Components sit at bits [23:16] (red), [15:8] (green) and [7:0] (blue) of the 24-bit pixel buses (default `CW`=8).
- R2: `fg_o` is the OR of the three component results, so one component above its threshold makes the pixel foreground.
- R3: A component counts as foreground only when its difference is strictly greater than its threshold. A difference equal to the threshold gives 0.
- R4: For each component, the threshold used in frame n+1 is floor(sum of that component's differences over the valid pixels of frame n / number of valid pixels in frame n).
- R5: Until the first frame with valid pixels has been measured, every component uses `dflt_thr`. Once a measured mean exists, `dflt_thr` has no effect.
- R6: A frame with no valid pixels leaves all thresholds unchanged.
- R7: `pix_vld_o`, `fsync_o` and `rsync_o` equal `pix_vld_i`, `fsync_i` and `rsync_i` delayed by exactly two clock cycles. The flag for a pixel appears in the same cycle as its `pix_vld_o`.
- R8: `fg_o` is 0 in every cycle whose `pix_vld_o` is 0.
- R9: A frame in which every difference is at its maximum value yields a mean equal to that maximum, with no accumulator wrap. In the next frame, maximum differences therefore give 0.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dflt_thr | input | CW | Threshold used before the first measured mean |
| pix_vld_i | input | 1 | Live and background pixels valid this cycle |
| fsync_i | input | 1 | One-cycle pulse at the start of a frame |
| rsync_i | input | 1 | One-cycle pulse at the start of a row |
| live_rgb_i | input | 3*CW | Live video pixel |
| bg_rgb_i | input | 3*CW | Background pixel at the same position |
| pix_vld_o | output | 1 | Valid strobe delayed two cycles |
| fsync_o | output | 1 | Frame sync delayed two cycles |
| rsync_o | output | 1 | Row sync delayed two cycles |
| fg_o | output | 1 | Foreground flag of the pixel marked by `pix_vld_o` |

## Verification
The flag and the three strobes for an input cycle are due two rising edges later. The bench therefore samples on the falling edge and compares against an expectation it pushed two falling edges earlier. It makes this comparison every cycle, including the idle gaps, so stray strobes or flags are caught as well.

Threshold changes are due only after the divider finishes, which takes about fifty cycles at the bench's frame size. Each frame opens with an 80-cycle gap before its first row. During that gap the reference model switches to its newly computed means at the frame sync, and no pixel is compared until the hardware must have done the same.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NCOMP = 3;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_LOAD,
        DV_SHIFT,
        DV_STORE
    } div_state_e;
endpackage

// File: rtl/seg_absdiff.sv
module seg_absdiff #(
    parameter int CW = 8,
    parameter int NC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             fs_i,
    input  logic             rs_i,
    input  logic [NC*CW-1:0] live_i,
    input  logic [NC*CW-1:0] bg_i,
    output logic             vld_q,
    output logic             fs_q,
    output logic             rs_q,
    output logic [NC*CW-1:0] diff_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            fs_q  <= 1'b0;
            rs_q  <= 1'b0;
        end else begin
            vld_q <= vld_i;
            fs_q  <= fs_i;
            rs_q  <= rs_i;
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_comp
        logic [CW-1:0] a_w, b_w;
        assign a_w = live_i[c*CW +: CW];
        assign b_w = bg_i[c*CW +: CW];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                diff_q[c*CW +: CW] <= '0;
            else
                diff_q[c*CW +: CW] <= (a_w > b_w) ? (a_w - b_w) : (b_w - a_w);
        end
    end
endmodule

// File: rtl/seg_mean_acc.sv
module seg_mean_acc #(
    parameter int CW    = 8,
    parameter int NC    = 3,
    parameter int CNT_W = 21,
    parameter int ACC_W = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic                fs_i,
    input  logic [NC*CW-1:0]    diff_i,
    output logic [NC*ACC_W-1:0] sum_o,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                frame_end_o
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_o       = cnt_q;
    assign frame_end_o = fs_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (fs_i)
            cnt_q <= vld_i ? CNT_W'(1) : '0;
        else if (vld_i)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    for (genvar c = 0; c < NC; c++) begin : g_acc
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] add_w;
        assign add_w = ACC_W'(diff_i[c*CW +: CW]);
        assign sum_o[c*ACC_W +: ACC_W] = acc_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc_q <= '0;
            else if (fs_i)
                acc_q <= vld_i ? add_w : '0;
            else if (vld_i)
                acc_q <= acc_q + add_w;
        end
    end
endmodule

// File: rtl/seg_div_fsm.sv
module seg_div_fsm
    import seg_pkg::*;
#(
    parameter int CW    = 8,
    parameter int NC    = 3,
    parameter int CNT_W = 21,
    parameter int ACC_W = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NC*ACC_W-1:0] sum_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic [NC*CW-1:0]    thr_o,
    output logic                thr_ok_o,
    output logic                busy_o
);
    localparam int IDX_W  = (NC > 1) ? $clog2(NC) : 1;
    localparam int STEP_W = $clog2(ACC_W + 1);

    div_state_e state_q, state_d;

    logic [NC-1:0][ACC_W-1:0] sums_q;
    logic [CNT_W-1:0]         dvsr_q;
    logic [IDX_W-1:0]         idx_q;
    logic [ACC_W-1:0]         dvd_q;
    logic [ACC_W-1:0]         quo_q;
    logic [CNT_W:0]           rem_q;
    logic [STEP_W-1:0]        step_q;
    logic [NC-1:0][CW-1:0]    thr_q;
    logic                     thr_ok_q;

    logic [CNT_W:0] rem_sh_w;
    logic           fits_w;
    logic           last_step_w;
    logic           last_comp_w;

    assign rem_sh_w    = {rem_q[CNT_W-1:0], dvd_q[ACC_W-1]};
    assign fits_w      = rem_sh_w >= {1'b0, dvsr_q};
    assign last_step_w = step_q == STEP_W'(ACC_W - 1);
    assign last_comp_w = idx_q == IDX_W'(NC - 1);

    assign thr_o    = thr_q;
    assign thr_ok_o = thr_ok_q;
    assign busy_o   = state_q != DV_IDLE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_IDLE:  if (start_i && cnt_i != '0) state_d = DV_LOAD;
            DV_LOAD:  state_d = DV_SHIFT;
            DV_SHIFT: if (last_step_w) state_d = DV_STORE;
            DV_STORE: state_d = last_comp_w ? DV_IDLE : DV_LOAD;
            default:  state_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sums_q   <= '0;
            dvsr_q   <= '0;
            idx_q    <= '0;
            dvd_q    <= '0;
            quo_q    <= '0;
            rem_q    <= '0;
            step_q   <= '0;
            thr_q    <= '0;
            thr_ok_q <= 1'b0;
        end else begin
            unique case (state_q)
                DV_IDLE: begin
                    if (start_i && cnt_i != '0) begin
                        sums_q <= sum_i;
                        dvsr_q <= cnt_i;
                        idx_q  <= '0;
                    end
                end
                DV_LOAD: begin
                    dvd_q  <= sums_q[idx_q];
                    quo_q  <= '0;
                    rem_q  <= '0;
                    step_q <= '0;
                end
                DV_SHIFT: begin
                    rem_q  <= fits_w ? (rem_sh_w - {1'b0, dvsr_q}) : rem_sh_w;
                    quo_q  <= {quo_q[ACC_W-2:0], fits_w};
                    dvd_q  <= {dvd_q[ACC_W-2:0], 1'b0};
                    step_q <= step_q + STEP_W'(1);
                end
                DV_STORE: begin
                    thr_q[idx_q] <= quo_q[CW-1:0];
                    idx_q        <= idx_q + IDX_W'(1);
                    if (last_comp_w) thr_ok_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seg_thresh.sv
module seg_thresh #(
    parameter int CW = 8,
    parameter int NC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             fs_i,
    input  logic             rs_i,
    input  logic [NC*CW-1:0] diff_i,
    input  logic [NC*CW-1:0] thr_i,
    input  logic             thr_ok_i,
    input  logic [CW-1:0]    dflt_i,
    output logic             vld_q,
    output logic             fs_q,
    output logic             rs_q,
    output logic             fg_q
);
    logic [NC-1:0] hit_w;

    for (genvar c = 0; c < NC; c++) begin : g_cmp
        logic [CW-1:0] lim_w;
        assign lim_w    = thr_ok_i ? thr_i[c*CW +: CW] : dflt_i;
        assign hit_w[c] = diff_i[c*CW +: CW] > lim_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            fs_q  <= 1'b0;
            rs_q  <= 1'b0;
            fg_q  <= 1'b0;
        end else begin
            vld_q <= vld_i;
            fs_q  <= fs_i;
            rs_q  <= rs_i;
            fg_q  <= vld_i & (|hit_w);
        end
    end
endmodule

// File: rtl/frame_seg_top.sv
module frame_seg_top #(
    parameter int CW    = 8,
    parameter int IMG_W = 1280,
    parameter int IMG_H = 1024
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CW-1:0]                   dflt_thr,
    input  logic                            pix_vld_i,
    input  logic                            fsync_i,
    input  logic                            rsync_i,
    input  logic [seg_pkg::NCOMP*CW-1:0]    live_rgb_i,
    input  logic [seg_pkg::NCOMP*CW-1:0]    bg_rgb_i,
    output logic                            pix_vld_o,
    output logic                            fsync_o,
    output logic                            rsync_o,
    output logic                            fg_o
);
    localparam int NC    = seg_pkg::NCOMP;
    localparam int NPIX  = IMG_W * IMG_H;
    localparam int CNT_W = $clog2(NPIX + 1);
    localparam int ACC_W = CW + CNT_W;

    logic               s1_vld, s1_fs, s1_rs;
    logic [NC*CW-1:0]   s1_diff;
    logic [NC*ACC_W-1:0] fr_sum;
    logic [CNT_W-1:0]   fr_cnt;
    logic               fr_end;
    logic [NC*CW-1:0]   thr_w;
    logic               thr_ok_w;
    logic               div_busy;

    seg_absdiff #(.CW(CW), .NC(NC)) u_diff (
        .clk(clk), .rst_n(rst_n),
        .vld_i(pix_vld_i), .fs_i(fsync_i), .rs_i(rsync_i),
        .live_i(live_rgb_i), .bg_i(bg_rgb_i),
        .vld_q(s1_vld), .fs_q(s1_fs), .rs_q(s1_rs), .diff_q(s1_diff)
    );

    seg_mean_acc #(.CW(CW), .NC(NC), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s1_vld), .fs_i(s1_fs), .diff_i(s1_diff),
        .sum_o(fr_sum), .cnt_o(fr_cnt), .frame_end_o(fr_end)
    );

    seg_div_fsm #(.CW(CW), .NC(NC), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .start_i(fr_end), .sum_i(fr_sum), .cnt_i(fr_cnt),
        .thr_o(thr_w), .thr_ok_o(thr_ok_w), .busy_o(div_busy)
    );

    seg_thresh #(.CW(CW), .NC(NC)) u_thr (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s1_vld), .fs_i(s1_fs), .rs_i(s1_rs), .diff_i(s1_diff),
        .thr_i(thr_w), .thr_ok_i(thr_ok_w), .dflt_i(dflt_thr),
        .vld_q(pix_vld_o), .fs_q(fsync_o), .rs_q(rsync_o), .fg_q(fg_o)
    );
endmodule

// File: rtl/seg_chk.sv
module seg_chk #(
    parameter int CW = 8,
    parameter int NC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_vld_i,
    input logic             fsync_i,
    input logic             rsync_i,
    input logic             pix_vld_o,
    input logic             fsync_o,
    input logic             rsync_o,
    input logic             fg_o,
    input logic             busy,
    input logic [NC*CW-1:0] thr,
    input logic             thr_ok
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R7
    vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (pix_vld_o == $past(pix_vld_i, 2)));

    // R7
    fsync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (fsync_o == $past(fsync_i, 2)));

    // R7
    rsync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (rsync_o == $past(rsync_i, 2)));

    // R8
    fg_needs_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && fg_o) |-> $past(pix_vld_i, 2));

    // R6
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !busy && !$past(busy)) |-> $stable({thr_ok, thr}));
endmodule

bind frame_seg_top seg_chk #(.CW(CW), .NC(seg_pkg::NCOMP)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .pix_vld_i(pix_vld_i), .fsync_i(fsync_i), .rsync_i(rsync_i),
    .pix_vld_o(pix_vld_o), .fsync_o(fsync_o), .rsync_o(rsync_o), .fg_o(fg_o),
    .busy(div_busy), .thr(thr_w), .thr_ok(thr_ok_w)
);

// File: tb/sim_frame_seg_top.sv
module sim_frame_seg_top;
    localparam int CW  = 8;
    localparam int W   = 8;
    localparam int H   = 4;
    localparam int GAP = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dflt_thr = 8'd10;
    logic        pix_vld_i = 1'b0, fsync_i = 1'b0, rsync_i = 1'b0;
    logic [23:0] live_rgb_i = '0, bg_rgb_i = '0;
    logic        pix_vld_o, fsync_o, rsync_o, fg_o;

    always #10 clk = ~clk;

    frame_seg_top #(.CW(CW), .IMG_W(W), .IMG_H(H)) u0 (
        .clk(clk), .rst_n(rst_n), .dflt_thr(dflt_thr),
        .pix_vld_i(pix_vld_i), .fsync_i(fsync_i), .rsync_i(rsync_i),
        .live_rgb_i(live_rgb_i), .bg_rgb_i(bg_rgb_i),
        .pix_vld_o(pix_vld_o), .fsync_o(fsync_o), .rsync_o(rsync_o), .fg_o(fg_o)
    );

    int    checks = 0, errors = 0;
    string tag = "R10";
    int    msum [3];
    int    mcnt = 0;
    int    mthr [3];
    bit    mhave = 1'b0;
    logic [3:0] e1 = '0, e2 = '0;

    task automatic cyc(input bit v, input bit f, input bit r,
                       input logic [23:0] lv, input logic [23:0] bg);
        logic [3:0] got;
        bit         eg;
        @(negedge clk);
        got = {pix_vld_o, fsync_o, rsync_o, fg_o};
        checks++;
        if (got !== e2) begin
            errors++;
            $display("FAIL %s R7 {vld,fs,rs,fg} actual %b expected %b", tag, got, e2);
        end
        if (f) begin
            if (mcnt > 0) begin
                for (int c = 0; c < 3; c++) mthr[c] = msum[c] / mcnt;
                mhave = 1'b1;
            end
            for (int c = 0; c < 3; c++) msum[c] = 0;
            mcnt = 0;
        end
        eg = 1'b0;
        if (v) begin
            for (int c = 0; c < 3; c++) begin
                int a, b, d, t;
                a = int'(lv[c*8 +: 8]);
                b = int'(bg[c*8 +: 8]);
                d = (a > b) ? a - b : b - a;
                t = mhave ? mthr[c] : int'(dflt_thr);
                if (d > t) eg = 1'b1;
                msum[c] += d;
            end
            mcnt++;
        end
        pix_vld_i  = v;
        fsync_i    = f;
        rsync_i    = r;
        live_rgb_i = lv;
        bg_rgb_i   = bg;
        e2 = e1;
        e1 = {v, f, r, v & eg};
    endtask

    function automatic logic [23:0] pix(input int kind, input int i, input bit is_bg);
        logic [23:0] p;
        p = '0;
        case (kind)
            0: for (int c = 0; c < 3; c++)
                   p[c*8 +: 8] = is_bg ? 8'((i*91 + c*17 + 5) % 256)
                                       : 8'((i*37 + c*53) % 256);
            1: p = is_bg ? {8'd100, 8'd50, 8'd7} : {8'd120, 8'd50, 8'd7};
            2: case (i % 4)
                   0: p = is_bg ? {8'd100, 8'd60, 8'd9} : {8'd120, 8'd60, 8'd9};
                   1: p = is_bg ? {8'd100, 8'd60, 8'd9} : {8'd121, 8'd60, 8'd9};
                   2: p = is_bg ? {8'd100, 8'd60, 8'd9} : {8'd80,  8'd60, 8'd9};
                   default: p = is_bg ? {8'd100, 8'd60, 8'd9} : {8'd100, 8'd61, 8'd9};
               endcase
            default: p = is_bg ? 24'h000000 : 24'hFFFFFF;
        endcase
        return p;
    endfunction

    task automatic frame(input int kind, input bit with_pix);
        cyc(1'b0, 1'b1, 1'b0, '0, '0);
        repeat (GAP) cyc(1'b0, 1'b0, 1'b0, '0, '0);
        if (with_pix) begin
            for (int r = 0; r < H; r++) begin
                cyc(1'b0, 1'b0, 1'b1, '0, '0);
                for (int c = 0; c < W; c++) begin
                    int i;
                    i = r*W + c;
                    cyc(1'b1, 1'b0, 1'b0, pix(kind, i, 1'b0), pix(kind, i, 1'b1));
                    if (kind == 0 && (c % 3) == 1) cyc(1'b0, 1'b0, 1'b0, '0, '0);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin msum[c] = 0; mthr[c] = 0; end
        repeat (3) @(negedge clk);
        checks++;
        if ({pix_vld_o, fsync_o, rsync_o, fg_o} !== 4'b0) begin
            errors++;
            $display("FAIL R10 reset outputs actual %b expected 0000",
                     {pix_vld_o, fsync_o, rsync_o, fg_o});
        end
        rst_n = 1'b1;
        tag = "R10";
        repeat (3) cyc(1'b0, 1'b0, 1'b0, '0, '0);
        tag = "R5 R1 R2 R8";
        frame(0, 1'b1);
        tag = "R4 R1 R2";
        frame(0, 1'b1);
        tag = "R4";
        frame(1, 1'b1);
        frame(1, 1'b1);
        tag = "R6";
        frame(1, 1'b0);
        dflt_thr = 8'd0;
        tag = "R3 R2 R1 R5 R6";
        frame(2, 1'b1);
        tag = "R9";
        frame(3, 1'b1);
        frame(3, 1'b1);
        repeat (4) cyc(1'b0, 1'b0, 1'b0, '0, '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule